// File: doc/BRIEF.md
# Battery Monitor Power-Mode Sequencer

The sequencer decides when a battery monitor is awake and when it starts work. It has three modes: run, doze and off. In run mode it issues a one-cycle cycle-start strobe once every second. The seconds are counted from a 1 ms tick input. The strobe starts the monitor's measure, compute, protect and update pass. In doze mode the same strobe comes only once every programmable number of seconds. The sequencer returns to run mode when the sensed current reaches a selectable wake threshold in either direction, or when a fault is flagged. In off mode all counting stops. The only way out of off mode is a pack-voltage-above-startup flag.

The host asks for doze or off through request inputs. Doze is granted only after the current has stayed under the wake threshold for one whole run-mode second. Once per second, and only while awake, the block samples the active-low system-present pin through a synchronizer and reports the result as a flag.

Top module: `gauge_pwr_seq`

## Requirements
- R1: After reset the mode is run (`mode` = 2'b00), `cycle_go` and `sys_present` are 0, and the millisecond counter is cleared. The first `cycle_go` appears on the cycle after the TICKS_PER_SEC-th accepted `ms_tick`.
- R2: In run mode, every TICKS_PER_SEC-th `ms_tick` (one second) is followed on the next cycle by `cycle_go` high for exactly one clock.
- R3: In doze mode (`mode` = 2'b01), `cycle_go` follows only every N-th second boundary, where N is `sleep_secs` and a value of 0 counts as 1. The seconds are counted from doze entry.
- R4: `cur_word` is two's complement in units of 0.25 mV. Current flow means that its absolute value is at least the threshold picked by `wake_sel`: 00 → 4 LSB (1 mV), 01 → 9 (2.25 mV), 10 → 18 (4.5 mV), 11 → 36 (9 mV). The most negative word is handled without overflow.
- R5: In doze mode, current flow or `fault` moves the mode to run at the next edge, unless `req_off` is also high.
- R6: Run moves to doze only when `req_sleep` is high, `fault` is low, there is no current flow now, and there was no current flow during the whole previous run-mode second.
- R7: `req_off` in run or doze mode moves the mode to off (`mode` = 2'b10) at the next edge, ahead of any other transition. While off, ticks are ignored, no `cycle_go` is issued and the millisecond count stays cleared. The block leaves off for run only when `pack_ok` is high, and its first strobe then follows TICKS_PER_SEC ticks later.
- R8: `sys_pres_n` passes through a SYNC_STAGES-flop synchronizer that resets high. At each second boundary in run or doze, `sys_present` takes the inverted synchronized value, so a low pin means present. `sys_present` is cleared one cycle after entering off.
- R9: When a second boundary and a mode change fall on the same edge, the strobe decision uses the mode held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| cur_word | input | CUR_W | Signed current word, 0.25 mV per LSB |
| wake_sel | input | 2 | Wake-threshold select code |
| fault | input | 1 | Fault flag, wakes from doze |
| sys_pres_n | input | 1 | System-present pin, low = present |
| pack_ok | input | 1 | Pack voltage above startup level |
| req_sleep | input | 1 | Host request for doze |
| req_off | input | 1 | Host request for off |
| sleep_secs | input | SLP_W | Doze strobe interval in seconds |
| mode | output | 2 | Current mode: 00 run, 01 doze, 10 off |
| cycle_go | output | 1 | One-cycle cycle-start strobe |
| sys_present | output | 1 | Latched system-present flag |

## Verification
The riskiest overlap is a doze wake on the same edge as the second boundary that ends a doze interval. In that case the strobe must still fire, because it follows the old mode, while the mode switches to run. The bench provokes this by watching its reference model's millisecond count and raising `fault` exactly on the tick that closes the second. On the following cycle it requires both `cycle_go` high and `mode` equal to run. Random stimulus then creates more overlaps of this kind: sleep requests on a second boundary and off requests during a wake. Every cycle is compared against the model.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef enum logic [1:0] {
      MODE_RUN  = 2'b00,
      MODE_DOZE = 2'b01,
      MODE_OFF  = 2'b10
   } pmode_e;

   // wake threshold in 0.25 mV LSB for each select code
   function automatic int unsigned wake_lsb(input logic [1:0] sel);
      case (sel)
         2'b00:   return 4;
         2'b01:   return 9;
         2'b10:   return 18;
         default: return 36;
      endcase
   endfunction

endpackage

// File: rtl/seq_wake_cmp.sv
module seq_wake_cmp #(
   parameter int unsigned CUR_W = 16
) (
   input  logic signed [CUR_W-1:0] cur_word,
   input  logic [1:0]              wake_sel,
   output logic                    below
);
   import pwr_seq_pkg::*;

   localparam int unsigned MW = CUR_W + 1;

   generate
      if (CUR_W < 7) begin : g_bad_width
         $error("seq_wake_cmp: CUR_W must hold the largest threshold (36)");
      end
   endgenerate

   logic [MW-1:0] ext;
   logic [MW-1:0] mag;
   logic [MW-1:0] thr;

   // one extra bit keeps the most negative word representable after negation
   assign ext   = {cur_word[CUR_W-1], cur_word};
   assign mag   = cur_word[CUR_W-1] ? (~ext + 1'b1) : ext;
   assign thr   = MW'(wake_lsb(wake_sel));
   assign below = (mag < thr);

endmodule

// File: rtl/seq_pres_sync.sv
module seq_pres_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic pin_q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign pin_q = pin;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk) begin
            if (!rst_n) sr <= '1;
            else if (STAGES == 1) sr <= pin;
            else sr <= {sr[STAGES-2:0], pin};
         end
         assign pin_q = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/seq_sec_timer.sv
module seq_sec_timer #(
   parameter int unsigned TICKS_PER_SEC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ms_tick,
   output logic sec_pulse
);
   generate
      if (TICKS_PER_SEC < 2) begin : g_bad_tps
         $error("seq_sec_timer: TICKS_PER_SEC must be at least 2");
      end
   endgenerate

   localparam int unsigned CW = $clog2(TICKS_PER_SEC);
   localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

   logic [CW-1:0] ms_cnt;

   assign sec_pulse = run && ms_tick && (ms_cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)       ms_cnt <= '0;
      else if (!run)    ms_cnt <= '0;
      else if (ms_tick) ms_cnt <= sec_pulse ? '0 : ms_cnt + 1'b1;
   end

   // R7: a stopped timer holds a cleared count
   a_r7_timer_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!run) |=> (ms_cnt == '0));

   // R2: a boundary never repeats on back-to-back cycles
   a_r2_pulse_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |=> !sec_pulse);

endmodule

// File: rtl/seq_mode_fsm.sv
module seq_mode_fsm #(
   parameter int unsigned SLP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_pulse,
   input  logic             below,
   input  logic             fault,
   input  logic             req_sleep,
   input  logic             req_off,
   input  logic             pack_ok,
   input  logic             pres_pin_q,
   input  logic [SLP_W-1:0] sleep_secs,
   output pwr_seq_pkg::pmode_e st,
   output logic             cycle_go,
   output logic             sys_present
);
   import pwr_seq_pkg::*;

   generate
      if (SLP_W < 1) begin : g_bad_slp
         $error("seq_mode_fsm: SLP_W must be at least 1");
      end
   endgenerate

   pmode_e           nxt;
   logic [SLP_W-1:0] secs_cnt;
   logic [SLP_W-1:0] lim_m1;
   logic             doze_due;
   logic             quiet_acc;
   logic             quiet_full;

   assign lim_m1   = (sleep_secs == '0) ? '0 : sleep_secs - 1'b1;
   assign doze_due = sec_pulse && (secs_cnt >= lim_m1);

   always_comb begin
      nxt = st;
      case (st)
         MODE_RUN: begin
            if (req_off) nxt = MODE_OFF;
            else if (req_sleep && quiet_full && below && !fault) nxt = MODE_DOZE;
         end
         MODE_DOZE: begin
            if (req_off) nxt = MODE_OFF;
            else if (!below || fault) nxt = MODE_RUN;
         end
         default: begin
            if (pack_ok) nxt = MODE_RUN;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= MODE_RUN;
         cycle_go    <= 1'b0;
         secs_cnt    <= '0;
         quiet_acc   <= 1'b1;
         quiet_full  <= 1'b0;
         sys_present <= 1'b0;
      end else begin
         st       <= nxt;
         cycle_go <= ((st == MODE_RUN) && sec_pulse) || ((st == MODE_DOZE) && doze_due);

         if (st != MODE_DOZE)  secs_cnt <= '0;
         else if (sec_pulse)   secs_cnt <= doze_due ? '0 : secs_cnt + 1'b1;

         if (st != MODE_RUN) begin
            quiet_acc  <= 1'b1;
            quiet_full <= 1'b0;
         end else if (sec_pulse) begin
            quiet_full <= quiet_acc && below;
            quiet_acc  <= 1'b1;
         end else begin
            quiet_acc  <= quiet_acc && below;
         end

         if (st == MODE_OFF)  sys_present <= 1'b0;
         else if (sec_pulse)  sys_present <= !pres_pin_q;
      end
   end

   // R5: current flow or fault in doze wakes to run unless off is requested
   a_r5_wake: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == MODE_DOZE) && !req_off && (fault || !below)) |=> (st == MODE_RUN));

   // R6: doze is only entered from run on a host request
   a_r6_sleep_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == MODE_RUN) && !req_sleep) |=> (st != MODE_DOZE));

   // R7: off holds until the pack voltage flag
   a_r7_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == MODE_OFF) && !pack_ok) |=> (st == MODE_OFF));

   // R7: off is reached from run or doze whenever requested
   a_r7_off_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ((st != MODE_OFF) && req_off) |=> (st == MODE_OFF));

   // R7: no strobe follows a cycle spent in off
   a_r7_no_go_off: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_go |-> ($past(st) != MODE_OFF));

   // R8: presence flag is cleared after a cycle in off
   a_r8_pres_off: assert property (@(posedge clk) disable iff (!rst_n)
      (st == MODE_OFF) |=> !sys_present);

   // R2: strobe lasts one clock
   a_r2_go_single: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_go |=> !cycle_go);

endmodule

// File: rtl/gauge_pwr_seq.sv
module gauge_pwr_seq #(
   parameter int unsigned TICKS_PER_SEC = 1000,
   parameter int unsigned CUR_W         = 16,
   parameter int unsigned SLP_W         = 8,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ms_tick,
   input  logic signed [CUR_W-1:0] cur_word,
   input  logic [1:0]              wake_sel,
   input  logic                    fault,
   input  logic                    sys_pres_n,
   input  logic                    pack_ok,
   input  logic                    req_sleep,
   input  logic                    req_off,
   input  logic [SLP_W-1:0]        sleep_secs,
   output logic [1:0]              mode,
   output logic                    cycle_go,
   output logic                    sys_present
);
   import pwr_seq_pkg::*;

   pmode_e st;
   logic   sec_pulse;
   logic   below;
   logic   pres_q;
   logic   awake;

   assign awake = (st != MODE_OFF);
   assign mode  = st;

   seq_sec_timer #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (awake),
      .ms_tick   (ms_tick),
      .sec_pulse (sec_pulse)
   );

   seq_wake_cmp #(.CUR_W(CUR_W)) u_cmp (
      .cur_word (cur_word),
      .wake_sel (wake_sel),
      .below    (below)
   );

   seq_pres_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (sys_pres_n),
      .pin_q (pres_q)
   );

   seq_mode_fsm #(.SLP_W(SLP_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sec_pulse   (sec_pulse),
      .below       (below),
      .fault       (fault),
      .req_sleep   (req_sleep),
      .req_off     (req_off),
      .pack_ok     (pack_ok),
      .pres_pin_q  (pres_q),
      .sleep_secs  (sleep_secs),
      .st          (st),
      .cycle_go    (cycle_go),
      .sys_present (sys_present)
   );

   // R9: strobe in a cycle implies a second boundary on the edge before
   a_r9_go_from_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_go |-> $past(sec_pulse));

endmodule

// File: tb/test_gauge_pwr_seq.sv
`timescale 1ns/1ps
module test_gauge_pwr_seq;

   localparam int TPS  = 8;
   localparam int CW   = 16;
   localparam int SW   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ms_tick = 1'b0;
   logic signed [CW-1:0] cur_word = '0;
   logic [1:0] wake_sel = 2'b00;
   logic fault = 1'b0;
   logic sys_pres_n = 1'b1;
   logic pack_ok = 1'b0;
   logic req_sleep = 1'b0;
   logic req_off = 1'b0;
   logic [SW-1:0] sleep_secs = '0;
   logic [1:0] mode;
   logic cycle_go;
   logic sys_present;

   always #10 clk = ~clk;

   gauge_pwr_seq #(.TICKS_PER_SEC(TPS), .CUR_W(CW), .SLP_W(SW), .SYNC_STAGES(2)) i_gauge_pwr_seq (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cur_word(cur_word),
      .wake_sel(wake_sel), .fault(fault), .sys_pres_n(sys_pres_n),
      .pack_ok(pack_ok), .req_sleep(req_sleep), .req_off(req_off),
      .sleep_secs(sleep_secs), .mode(mode), .cycle_go(cycle_go),
      .sys_present(sys_present)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;
   int tick_mode = 1;
   int tick_total = 0;

   // reference model state
   int m_mode, m_ms, m_secs, m_prev_mode;
   bit m_qacc, m_qfull, m_go, m_pres, m_p1, m_p2;

   function automatic int thr_of(input logic [1:0] s);
      case (s) 2'b00: return 4; 2'b01: return 9; 2'b10: return 18; default: return 36; endcase
   endfunction

   function automatic int mag_of(input logic signed [CW-1:0] c);
      int v;
      v = int'(c);
      return (v < 0) ? -v : v;
   endfunction

   task automatic chk(input string tag, input bit ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_mode = 0; m_ms = 0; m_secs = 0; m_qacc = 1; m_qfull = 0;
      m_go = 0; m_pres = 0; m_p1 = 1; m_p2 = 1; m_prev_mode = 0;
   endtask

   task automatic model_step();
      bit below, sp, awake, due;
      int lim, n_mode;
      below = mag_of(cur_word) < thr_of(wake_sel);
      awake = (m_mode != 2);
      sp = awake && ms_tick && (m_ms == TPS-1);
      lim = (sleep_secs == 0) ? 1 : int'(sleep_secs);
      due = sp && (m_secs >= lim-1);
      n_mode = m_mode;
      if (m_mode == 0) begin
         if (req_off) n_mode = 2;
         else if (req_sleep && m_qfull && below && !fault) n_mode = 1;
      end else if (m_mode == 1) begin
         if (req_off) n_mode = 2;
         else if (!below || fault) n_mode = 0;
      end else if (pack_ok) n_mode = 0;
      m_go = ((m_mode == 0) && sp) || ((m_mode == 1) && due);
      if (m_mode == 2) m_pres = 0;
      else if (sp) m_pres = !m_p2;
      m_p2 = m_p1; m_p1 = sys_pres_n;
      if (m_mode != 1) m_secs = 0;
      else if (sp) m_secs = due ? 0 : m_secs + 1;
      if (m_mode != 0) begin m_qacc = 1; m_qfull = 0; end
      else if (sp) begin m_qfull = m_qacc && below; m_qacc = 1; end
      else m_qacc = m_qacc && below;
      if (!awake) m_ms = 0;
      else if (ms_tick) m_ms = sp ? 0 : m_ms + 1;
      m_prev_mode = m_mode;
      m_mode = n_mode;
   endtask

   task automatic cycle();
      @(posedge clk);
      if (ms_tick && m_mode != 2) tick_total++;
      model_step();
      @(negedge clk);
      chk(m_prev_mode == 1 ? "R3 doze strobe" : "R2 run strobe", cycle_go == m_go, cycle_go, m_go);
      chk("R5 R6 R7 mode", int'(mode) == m_mode, mode, m_mode);
      chk("R8 presence", sys_present == m_pres, sys_present, m_pres);
      if (tick_mode == 1) ms_tick = ~ms_tick;
      else ms_tick = ($urandom % 2) == 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic reach_doze();
      int n;
      cur_word = '0; fault = 0; req_off = 0; req_sleep = 1;
      n = 0;
      while (mode != 2'b01 && n < 200) begin cycle(); n++; end
      chk("R6 doze reached", mode == 2'b01, mode, 1);
      req_sleep = 0;
   endtask

   initial begin
      int n, t0, sel, th;
      void'($urandom(32'd4242));
      do_reset();
      // R1 reset state
      chk("R1 reset mode", mode == 2'b00, mode, 0);
      chk("R1 reset strobe", cycle_go == 1'b0, cycle_go, 0);
      chk("R1 reset presence", sys_present == 1'b0, sys_present, 0);
      tick_mode = 1; ms_tick = 1; tick_total = 0;
      n = 0;
      while (!cycle_go && n < 200) begin cycle(); n++; end
      chk("R1 ticks to first strobe", tick_total == TPS, tick_total, TPS);

      // R2 period in run mode: TPS ticks at one per two cycles
      cycle(); n = 1;
      while (!cycle_go && n < 200) begin cycle(); n++; end
      chk("R2 run period", n == 2*TPS, n, 2*TPS);

      // R6 no doze while current flows
      wake_sel = 2'b00; cur_word = 16'sd10; req_sleep = 1;
      repeat (60) cycle();
      chk("R6 stays run with current", mode == 2'b00, mode, 0);
      reach_doze();

      // R3 doze interval of three seconds
      sleep_secs = 3;
      n = 0;
      while (!cycle_go && n < 300) begin cycle(); n++; end
      cycle(); n = 1;
      while (!cycle_go && n < 300) begin cycle(); n++; end
      chk("R3 doze period", n == 3*2*TPS, n, 3*2*TPS);

      // R4 thresholds for each code, both signs
      for (int s = 0; s < 4; s++) begin
         sel = s; wake_sel = s[1:0]; th = thr_of(wake_sel);
         cur_word = (s % 2 == 0) ? CW'(-(th-1)) : CW'(th-1);
         repeat (5) cycle();
         chk("R4 below threshold keeps doze", mode == 2'b01, mode, 1);
         cur_word = (s % 2 == 0) ? CW'(th) : CW'(-th);
         cycle();
         chk("R4 at threshold wakes", mode == 2'b00, mode, 0);
         reach_doze();
      end
      // R4 most negative word wakes
      wake_sel = 2'b11; cur_word = 16'sh8000;
      cycle();
      chk("R4 most negative wakes", mode == 2'b00, mode, 0);
      reach_doze();

      // R9 fault on the edge closing a doze interval
      sleep_secs = 1;
      n = 0;
      while (!(m_mode == 1 && m_ms == TPS-1 && ms_tick) && n < 100) begin cycle(); n++; end
      fault = 1;
      cycle();
      fault = 0;
      chk("R9 strobe on wake edge", cycle_go == 1'b1, cycle_go, 1);
      chk("R9 mode after wake edge", mode == 2'b00, mode, 0);
      chk("R5 fault wake", mode == 2'b00, mode, 0);

      // R7 off mode
      req_off = 1; cycle(); req_off = 0;
      chk("R7 off entered", mode == 2'b10, mode, 2);
      n = 0;
      repeat (60) begin cycle(); if (cycle_go) n++; end
      chk("R7 no strobe while off", n == 0, n, 0);
      chk("R8 presence cleared off", sys_present == 1'b0, sys_present, 0);
      pack_ok = 1; cycle(); pack_ok = 0;
      chk("R7 off exit on pack flag", mode == 2'b00, mode, 0);
      tick_total = 0; n = 0;
      while (!cycle_go && n < 200) begin cycle(); n++; end
      chk("R7 ticks to first strobe after off", tick_total == TPS, tick_total, TPS);

      // R8 presence sampling
      sys_pres_n = 0;
      repeat (4*TPS) cycle();
      chk("R8 present when pin low", sys_present == 1'b1, sys_present, 1);
      sys_pres_n = 1;
      repeat (4*TPS) cycle();
      chk("R8 absent when pin high", sys_present == 1'b0, sys_present, 0);

      // constrained random phase
      tick_mode = 2;
      for (int i = 0; i < 6000; i++) begin
         int r;
         r = $urandom % 100;
         if (r < 80) cur_word = CW'(int'($urandom % 11) - 5);
         else if (r < 95) cur_word = CW'(int'($urandom % 81) - 40);
         else cur_word = CW'($urandom);
         fault     = ($urandom % 100) < 2;
         req_sleep = ($urandom % 2) == 0;
         req_off   = ($urandom % 200) == 0;
         pack_ok   = ($urandom % 10) == 0;
         if (($urandom % 20) == 0) sys_pres_n = ~sys_pres_n;
         if (($urandom % 50) == 0) wake_sel = 2'($urandom);
         if (($urandom % 100) == 0) sleep_secs = SW'($urandom % 4);
         cycle();
      end

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule